// File: doc/BRIEF.md
# One-Time-Programmable ROM Model

This block is a synthesizable, cycle-level model of a byte-wide read-only memory that can be programmed once. One combinational decoder reads the active-low chip select, the active-low output gate and two flags. One flag marks the high programming supply on the output-gate pin. The other marks the high identifier voltage on address line 9. From these the decoder picks one of six access modes. A registered mode state then sets what the data output shows during the following cycle.

A new part reads all ones. A program access can only turn bits from 1 to 0, so writing the same cell again can never set a bit back to 1. Two hidden bytes, the maker code and the part code, are read through the identification mode. Address bit 0 picks between them. The address width is a parameter. The full-size part uses 16 bits, and the default of 10 keeps the model small for elaboration. Analog levels, supply currents and the width of programming pulses are not modelled.

The mode state is a registered enum. It is sampled from the decoder on every clock edge and takes one of these values:

- `MODE_STANDBY`
- `MODE_OUT_OFF`
- `MODE_READ`
- `MODE_IDENT`
- `MODE_PROGRAM`
- `MODE_INHIBIT`

Any mode may follow any other mode. The transition taken at an edge is the decoder result for the inputs at that edge:

- chip select high with no programming flag goes to `MODE_STANDBY`
- chip select high with the programming flag goes to `MODE_INHIBIT`
- chip select low with the programming flag goes to `MODE_PROGRAM`
- chip select low with the output gate high goes to `MODE_OUT_OFF`
- chip select low with the output gate low goes to `MODE_IDENT` when the identifier condition holds, and otherwise to `MODE_READ`

Top module: `otp_rom_top`

## Requirements
- R1: With `ce_n`=0, `oe_n`=0 and `vpp_hv`=0, and the identification condition not met, the cycle after the sampling edge shows `drive`=1 and `dout` equal to the stored byte at `addr`.
- R2: With `ce_n`=0, `oe_n`=1 and `vpp_hv`=0, the following cycle shows `drive`=0 and `dout`=0x00. This holds whether or not `id_hv` is set.
- R3: With `ce_n`=1 and `vpp_hv`=0, the following cycle shows `drive`=0 and `dout`=0x00, whatever the values of `oe_n` and `addr`.
- R4: With `ce_n`=0 and `vpp_hv`=1, the rising edge stores (old byte AND `din`) at `addr`, and the following cycle shows `drive`=0.
- R5: After reset, every cell reads 0xFF. A bit that has been programmed to 0 stays 0, even when it is programmed again with 0xFF.
- R6: With `ce_n`=1 and `vpp_hv`=1, no cell changes and the following cycle shows `drive`=0.
- R7: Identification is entered when all of these hold: `id_hv`=1, `ce_n`=0, `oe_n`=0, `vpp_hv`=0, and every `addr` bit other than bit 0 and bit 9 is 0. It returns `MFR_ID` (default 0x1E) when `addr[0]`=0, and `DEV_ID` (default 0x0D) when `addr[0]`=1, with `drive`=1.
- R8: With `id_hv`=1 but some `addr` bit other than bit 0 and bit 9 set, the access is a normal read of the array.
- R9: While `rst_n`=0, and in the first cycle after its release, `drive`=0 and `dout`=0x00.
- R10: Program accesses on back-to-back cycles to different addresses each take effect, at one byte per edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low; erases the model |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Byte to program |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output gate, active low |
| vpp_hv | input | 1 | Programming supply present on the output-gate pin |
| id_hv | input | 1 | Identifier voltage present on address line 9 |
| dout | output | DATA_W | Read data; 0x00 when not driven |
| drive | output | 1 | High when `dout` carries valid data (stands for the outputs leaving high impedance) |

## Verification
The bench reprograms a cell with 0xFF and then with a partial mask. A model that overwrote cells instead of ANDing them would read back set bits that should have stayed cleared. It then reads the identifier bytes at addresses that also hold programmed array data. A decoder that ignored `id_hv` would return the array byte, and one that dropped the mid-bit test would return an identifier byte where a plain read is due. Inhibit and output-disable accesses are followed by read-backs through the normal read path, which would expose a stray write or a leaking output enable. Back-to-back program cycles to two addresses would catch a write path that loses every other byte.

// File: rtl/otp_rom_pkg.sv
package otp_rom_pkg;
    typedef enum logic [2:0] {
        MODE_STANDBY,
        MODE_OUT_OFF,
        MODE_READ,
        MODE_IDENT,
        MODE_PROGRAM,
        MODE_INHIBIT
    } otp_mode_e;
endpackage

// File: rtl/otp_mode_decode.sv
module otp_mode_decode
    import otp_rom_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      vpp_hv,
    input  logic      id_hv,
    input  logic      rest_zero,
    output otp_mode_e mode
);
    // Priority: chip select, then programming supply, then output gate, then identifier.
    always_comb begin
        if (ce_n) begin
            mode = vpp_hv ? MODE_INHIBIT : MODE_STANDBY;
        end else if (vpp_hv) begin
            mode = MODE_PROGRAM;
        end else if (oe_n) begin
            mode = MODE_OUT_OFF;
        end else if (id_hv && rest_zero) begin
            mode = MODE_IDENT;
        end else begin
            mode = MODE_READ;
        end
    end
endmodule

// File: rtl/otp_cell_array.sv
module otp_cell_array #(
    parameter  int ADDR_W = 10,
    parameter  int DATA_W = 8,
    localparam int DEPTH  = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    // Each stored bit is 1 once it has been burned to 0, so reset gives an all-ones part.
    logic [DATA_W-1:0] burned_q [DEPTH];
    logic [DATA_W-1:0] rd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                burned_q[i] <= '0;
            end
            rd_q <= '0;
        end else begin
            if (we) begin
                burned_q[addr] <= burned_q[addr] | ~wdata;
            end
            rd_q <= ~burned_q[addr];
        end
    end

    assign rdata = rd_q;

    // R5: a write never returns a burned bit to the unburned state.
    assert_no_unburn_R5: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> ((~burned_q[$past(addr)] & $past(burned_q[addr])) == '0));
endmodule

// File: rtl/otp_rom_top.sv
module otp_rom_top
    import otp_rom_pkg::*;
#(
    parameter int              ADDR_W = 10,
    parameter int              DATA_W = 8,
    parameter logic [DATA_W-1:0] MFR_ID = 8'h1E,
    parameter logic [DATA_W-1:0] DEV_ID = 8'h0D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              vpp_hv,
    input  logic              id_hv,
    output logic [DATA_W-1:0] dout,
    output logic              drive
);
    localparam int              ID_PIN  = 9;
    localparam logic [ADDR_W-1:0] ID_KEEP = ADDR_W'(1) | (ADDR_W'(1) << ID_PIN);

    otp_mode_e         mode_d;
    otp_mode_e         mode_q;
    logic              sel_dev_q;
    logic              rest_zero;
    logic [DATA_W-1:0] arr_rdata;

    assign rest_zero = ((addr & ~ID_KEEP) == '0);

    otp_mode_decode u_decode (
        .ce_n      (ce_n),
        .oe_n      (oe_n),
        .vpp_hv    (vpp_hv),
        .id_hv     (id_hv),
        .rest_zero (rest_zero),
        .mode      (mode_d)
    );

    otp_cell_array #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_array (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mode_d == MODE_PROGRAM),
        .addr  (addr),
        .wdata (din),
        .rdata (arr_rdata)
    );

    // State register: the access mode sampled at the last edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_STANDBY;
            sel_dev_q <= 1'b0;
        end else begin
            mode_q    <= mode_d;
            sel_dev_q <= addr[0];
        end
    end

    // Output process.
    always_comb begin
        unique case (mode_q)
            MODE_READ: begin
                drive = 1'b1;
                dout  = arr_rdata;
            end
            MODE_IDENT: begin
                drive = 1'b1;
                dout  = sel_dev_q ? DEV_ID : MFR_ID;
            end
            default: begin
                drive = 1'b0;
                dout  = '0;
            end
        endcase
    end

    assert_read_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && !vpp_hv)) |-> drive);
    assert_gate_off_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && oe_n && !vpp_hv)) |-> (!drive && dout == '0));
    assert_standby_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ce_n)) |-> !drive);
    assert_program_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && vpp_hv)) |-> !drive);
    assert_ident_maker_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && !vpp_hv && id_hv && rest_zero && !addr[0]))
        |-> (drive && dout == MFR_ID));
    assert_ident_part_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(!ce_n && !oe_n && !vpp_hv && id_hv && rest_zero && addr[0]))
        |-> (drive && dout == DEV_ID));
    assert_after_reset_R9: assert property (@(posedge clk)
        (!$past(rst_n)) |-> !drive);
endmodule

// File: tb/otp_rom_top_tb_top.sv
`timescale 1ns/1ps
module otp_rom_top_tb_top;
    localparam int AW = 10;
    localparam logic [7:0] MFR = 8'h1E;
    localparam logic [7:0] DEV = 8'h0D;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          vpp_hv = 1'b0;
    logic          id_hv = 1'b0;
    logic [7:0]    dout;
    logic          drive;

    always #2.5 clk = ~clk;

    otp_rom_top #(.ADDR_W(AW), .DATA_W(8), .MFR_ID(MFR), .DEV_ID(DEV)) dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .ce_n(ce_n), .oe_n(oe_n),
        .vpp_hv(vpp_hv), .id_hv(id_hv), .dout(dout), .drive(drive)
    );

    typedef struct {
        int         due;
        logic       drv;
        logic [7:0] data;
        string      tag;
    } exp_t;

    exp_t       sb_q[$];
    exp_t       mon_e;
    logic [7:0] shadow [1<<AW];
    int         mon_cyc = 0;
    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;

    task automatic check(input string tag, input logic d, input logic [7:0] v,
                         input logic ed, input logic [7:0] ev);
        n_chk++;
        if (d !== ed || v !== ev) begin
            n_fail++;
            $display("FAIL %s: drive=%0b dout=%02h expected drive=%0b dout=%02h",
                     tag, d, v, ed, ev);
        end
    endtask

    // Monitor: compares results one step after each sampling edge.
    always @(posedge clk) begin
        #1;
        mon_cyc++;
        while (sb_q.size() > 0 && sb_q[0].due == mon_cyc) begin
            mon_e = sb_q.pop_front();
            check(mon_e.tag, drive, dout, mon_e.drv, mon_e.data);
        end
    end

    // Driver: applies one access and pushes what the next cycle must show.
    task automatic access(input logic ce, input logic oe, input logic vpp, input logic idh,
                          input logic [AW-1:0] a, input logic [7:0] d, input bit chk,
                          input logic edrv, input logic [7:0] edat, input string tag);
        exp_t item;
        @(negedge clk);
        ce_n = ce; oe_n = oe; vpp_hv = vpp; id_hv = idh; addr = a; din = d;
        if (!ce && vpp) shadow[a] = shadow[a] & d;
        if (chk) begin
            item.due = mon_cyc + 1; item.drv = edrv; item.data = edat; item.tag = tag;
            sb_q.push_back(item);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, input string tag);
        access(1'b0, 1'b0, 1'b0, 1'b0, a, 8'h00, 1'b1, 1'b1, shadow[a], tag);
    endtask

    task automatic prog(input logic [AW-1:0] a, input logic [7:0] d, input string tag);
        access(1'b0, 1'b1, 1'b1, 1'b0, a, d, 1'b1, 1'b0, 8'h00, tag);
    endtask

    initial begin
        for (int i = 0; i < (1<<AW); i++) shadow[i] = 8'hFF;
        repeat (3) @(negedge clk);
        check("R9 in reset", drive, dout, 1'b0, 8'h00);
        rst_n = 1'b1;
        access(1'b1, 1'b1, 1'b0, 1'b0, '0, 8'h00, 1'b1, 1'b0, 8'h00, "R9 after release");
        rd(10'd5, "R5 erased read");
        prog(10'd5, 8'hA5, "R4 program quiet");
        rd(10'd5, "R1 R4 read back");
        prog(10'd5, 8'hFF, "R5 reprogram FF");
        rd(10'd5, "R5 bits stay cleared");
        prog(10'd5, 8'h0F, "R4 second program");
        rd(10'd5, "R4 AND result");
        access(1'b0, 1'b1, 1'b0, 1'b0, 10'd5, 8'h00, 1'b1, 1'b0, 8'h00, "R2 output off");
        access(1'b1, 1'b0, 1'b0, 1'b0, 10'd5, 8'h00, 1'b1, 1'b0, 8'h00, "R3 standby oe low");
        access(1'b1, 1'b1, 1'b1, 1'b0, 10'd7, 8'h00, 1'b1, 1'b0, 8'h00, "R6 inhibit quiet");
        rd(10'd7, "R6 inhibit no write");
        prog(10'd1, 8'h3C, "R10 first write");
        prog(10'd2, 8'hC3, "R10 second write");
        rd(10'd1, "R10 read first");
        rd(10'd2, "R10 read second");
        prog(10'd3, 8'h55, "R8 prepare");
        access(1'b0, 1'b0, 1'b0, 1'b1, 10'h000, 8'h00, 1'b1, 1'b1, MFR, "R7 maker byte");
        access(1'b0, 1'b0, 1'b0, 1'b1, 10'h001, 8'h00, 1'b1, 1'b1, DEV, "R7 part byte");
        access(1'b0, 1'b0, 1'b0, 1'b1, 10'h201, 8'h00, 1'b1, 1'b1, DEV, "R7 part byte A9 set");
        access(1'b0, 1'b0, 1'b0, 1'b1, 10'h003, 8'h00, 1'b1, 1'b1, 8'h55, "R8 mid bit set reads array");
        access(1'b0, 1'b1, 1'b0, 1'b1, 10'h000, 8'h00, 1'b1, 1'b0, 8'h00, "R2 ident gated off");
        access(1'b1, 1'b1, 1'b0, 1'b0, '0, 8'h00, 1'b0, 1'b0, 8'h00, "idle");
        repeat (3) @(negedge clk);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(20000 * 5);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule